// File: doc/BRIEF.md
# Vector-Move-Eliminating Register Rename Stage

This block renames a group of up to four decoded operations each cycle for a small out-of-order core. Every operation carries a register class: general purpose, 128-bit vector, x87 stack or 256-bit vector. Its architectural source and destination registers are looked up in a speculative map table. Each destination that needs storage receives a physical register from a free pool. The renamed group appears on the outputs one clock later.

A register-to-register move between 128-bit vector registers never reaches an execution pipe and never takes a new physical register. The stage copies the source's physical register into the destination's map entry and reports the move as complete. The shared physical register gains one reference, and a per-register reference count keeps it allocated until every architectural owner has let go of it. Moves in every other class are renamed and sent to execution like any other operation.

A commit port keeps a second, retired copy of the map and releases the register that a committed write displaces. A flush throws away the speculative map and rebuilds both the map and the reference counts from the retired copy.

Top module: `vmove_rename`

## Requirements
- R1: For a group that is neither stalled nor flushed, `out_valid` one cycle later equals `in_valid` of that group. Lanes that are not valid output zeros.
- R2: A lane with `in_move`=1 and class code 1 (128-bit vector) is eliminated. It shows `out_elim`=1 and `out_exec`=0, its `out_pdst` equals its resolved source A mapping, and it uses no free register, so it renames even when the pool is empty.
- R3: A move in class 0 (general purpose), 2 (x87) or 3 (256-bit vector) receives a fresh physical register, with `out_exec`=1 and `out_elim`=0.
- R4: A source read by a later lane sees the mapping written by an earlier lane of the same group, including a mapping copied by an eliminated move.
- R5: `out_pold` is the mapping the destination held before this lane, taking earlier lanes of the same group into account. It is zero for lanes that write nothing.
- R6: Allocation hands out the lowest-numbered free physical registers, in ascending lane order.
- R7: A physical register returns to the pool only when its reference count reaches zero. An elimination and a release that hit the same register in the same cycle cancel out.
- R8: If the group needs more registers than the pool holds, `stall` is 1 in that cycle, no lane is output and the map is unchanged.
- R9: A commit sets the retired mapping of (`cm_cls`,`cm_arch`) to `cm_phys` and releases one reference to the physical register the retired map held there before.
- R10: `flush` discards the incoming group, restores the speculative map from the retired map (including a commit in the same cycle) and recomputes every reference count from that map.
- R11: After reset, architectural register {class, index} maps to physical register class*8+index, registers 32 to 47 are free, and all outputs and `stall` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 4 | Lane holds an operation |
| in_move | input | 4 | Lane is a register-to-register move (source A to destination) |
| in_wr | input | 4 | Non-move lane writes its destination |
| in_cls | input | 8 | Register class per lane, 2 bits: 0 general, 1 vector-128, 2 x87, 3 vector-256 |
| in_dst | input | 12 | Destination register index per lane, 3 bits |
| in_src_a | input | 12 | Source A register index per lane |
| in_src_b | input | 12 | Source B register index per lane |
| flush | input | 1 | Restore from the retired map and drop the group |
| cm_valid | input | 1 | Commit one register write |
| cm_cls | input | 2 | Class of the committed register |
| cm_arch | input | 3 | Index of the committed register |
| cm_phys | input | 6 | Physical register being committed |
| stall | output | 1 | Group cannot be renamed this cycle |
| out_valid | output | 4 | Renamed lane valid |
| out_exec | output | 4 | Lane goes to an execution pipe |
| out_elim | output | 4 | Lane was resolved in the map with zero latency |
| out_psrc_a | output | 24 | Physical source A per lane, 6 bits |
| out_psrc_b | output | 24 | Physical source B per lane |
| out_pdst | output | 24 | Physical destination per lane |
| out_pold | output | 24 | Previous mapping of the destination per lane |

## Verification
Two functions can hit the same physical register in one cycle. An eliminated move adds a reference to a register at the same moment a commit removes the last retired reference to it. The bench provokes this by committing a new owner for a vector register while the same group eliminates a move that reads that register's speculative mapping. The pool is empty at the time, so a single following allocation must stall. That stall shows the register was neither freed nor double counted. After a second commit frees a different register, the next allocation has to return that register and not the shared one.

// File: rtl/rn_pkg.sv
// Package rn_pkg
// Shared definitions for the rename stage: register class codes and the
// fixed number of classes. Assumes class codes fit in two bits.
package rn_pkg;

    localparam int NUM_CLS = 4;

    typedef enum logic [1:0] {
        RC_GPR  = 2'd0,
        RC_VEC  = 2'd1,
        RC_X87  = 2'd2,
        RC_WIDE = 2'd3
    } rc_e;

endpackage

// File: rtl/rn_free_pick.sv
// Module rn_free_pick
// Picks up to LANES free physical registers, lowest index first, from a
// free bitmap and reports how many were found (capped at LANES).
// Assumes the bitmap is a registered view of the reference counts.
module rn_free_pick #(
    parameter int PHYS  = 48,
    parameter int LANES = 4,
    parameter int PW    = 6,
    parameter int CW    = 3
) (
    input  logic [PHYS-1:0]           free_mask,
    output logic [LANES-1:0][PW-1:0]  pick,
    output logic [CW-1:0]             avail
);

    logic [PHYS-1:0] remain;
    logic            found;

    // Repeated find-first over the shrinking free set
    always_comb begin
        remain = free_mask;
        avail  = '0;
        pick   = '0;
        for (int k = 0; k < LANES; k++) begin
            found = 1'b0;
            for (int p = 0; p < PHYS; p++) begin
                if (!found && remain[p]) begin
                    pick[k]   = PW'(p);
                    remain[p] = 1'b0;
                    found     = 1'b1;
                end
            end
            if (found) avail = avail + CW'(1);
        end
    end

endmodule

// File: rtl/rn_group_resolve.sv
// Module rn_group_resolve
// Combinational rename of one group: classifies lanes, resolves sources and
// old destinations against the map and earlier lanes, assigns picked
// registers to allocating lanes in lane order, and builds the next map.
// Assumes pick holds ascending free registers and avail counts them.
module rn_group_resolve
    import rn_pkg::*;
#(
    parameter int LANES = 4,
    parameter int NARCH = 32,
    parameter int AIW   = 3,
    parameter int PW    = 6,
    parameter int CW    = 3
) (
    input  logic [NARCH-1:0][PW-1:0]  map_q,
    input  logic [LANES-1:0]          valid,
    input  logic [LANES-1:0]          move,
    input  logic [LANES-1:0]          wr,
    input  logic [LANES-1:0][1:0]     cls,
    input  logic [LANES-1:0][AIW-1:0] dst,
    input  logic [LANES-1:0][AIW-1:0] sa,
    input  logic [LANES-1:0][AIW-1:0] sb,
    input  logic [LANES-1:0][PW-1:0]  pick,
    input  logic [CW-1:0]             avail,
    output logic [LANES-1:0]          writes,
    output logic [LANES-1:0]          elim,
    output logic [LANES-1:0]          alloc,
    output logic [LANES-1:0][PW-1:0]  psa,
    output logic [LANES-1:0][PW-1:0]  psb,
    output logic [LANES-1:0][PW-1:0]  pdst,
    output logic [LANES-1:0][PW-1:0]  pold,
    output logic                      need_more,
    output logic [NARCH-1:0][PW-1:0]  map_next
);

    localparam int FW = $clog2(NARCH);
    localparam int LW = (LANES > 1) ? $clog2(LANES) : 1;

    logic [LANES-1:0][FW-1:0] fdst;
    logic [LANES-1:0][FW-1:0] fsa;
    logic [LANES-1:0][FW-1:0] fsb;
    logic [CW-1:0]            need;

    // Lane-ordered resolution with intra-group forwarding
    always_comb begin
        need = '0;
        for (int j = 0; j < LANES; j++) begin
            fdst[j]   = {cls[j], dst[j]};
            fsa[j]    = {cls[j], sa[j]};
            fsb[j]    = {cls[j], sb[j]};
            elim[j]   = valid[j] & move[j] & (rc_e'(cls[j]) == RC_VEC);
            writes[j] = valid[j] & (wr[j] | move[j]);
            alloc[j]  = writes[j] & ~elim[j];
            psa[j]    = map_q[fsa[j]];
            psb[j]    = map_q[fsb[j]];
            pold[j]   = map_q[fdst[j]];
            for (int i = 0; i < j; i++) begin
                if (writes[i] && fdst[i] == fsa[j])  psa[j]  = pdst[i];
                if (writes[i] && fdst[i] == fsb[j])  psb[j]  = pdst[i];
                if (writes[i] && fdst[i] == fdst[j]) pold[j] = pdst[i];
            end
            if (!writes[j]) pold[j] = '0;
            if (elim[j])       pdst[j] = psa[j];
            else if (alloc[j]) pdst[j] = pick[need[LW-1:0]];
            else               pdst[j] = '0;
            if (alloc[j]) need = need + CW'(1);
        end
        need_more = (need > avail);
    end

    // Next speculative map, later lanes overriding earlier ones
    always_comb begin
        map_next = map_q;
        for (int j = 0; j < LANES; j++) begin
            if (writes[j]) map_next[fdst[j]] = pdst[j];
        end
    end

endmodule

// File: rtl/rn_refcount.sv
// Module rn_refcount
// One reference counter per physical register. Allocation sets a count to
// one, eliminated moves add one per sharing lane, a commit release removes
// one, and a flush recounts references held by the retired map.
// Assumes an allocated register had a zero count and is not released in
// the same cycle.
module rn_refcount #(
    parameter int PHYS  = 48,
    parameter int LANES = 4,
    parameter int NARCH = 32,
    parameter int PW    = 6,
    parameter int CNT_W = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [LANES-1:0]          alloc_en,
    input  logic [LANES-1:0][PW-1:0]  alloc_idx,
    input  logic [LANES-1:0]          share_en,
    input  logic [LANES-1:0][PW-1:0]  share_idx,
    input  logic                      dec_en,
    input  logic [PW-1:0]             dec_idx,
    input  logic                      flush,
    input  logic [NARCH-1:0][PW-1:0]  ret_next,
    output logic [PHYS-1:0]           free_mask
);

    for (genvar p = 0; p < PHYS; p++) begin : g_cnt
        logic [CNT_W-1:0] cnt_q;
        logic [CNT_W-1:0] inc;
        logic [CNT_W-1:0] recount;
        logic             set_one;
        logic             dec;

        // Per-register event decode for this cycle
        always_comb begin
            inc     = '0;
            set_one = 1'b0;
            for (int l = 0; l < LANES; l++) begin
                if (share_en[l] && share_idx[l] == PW'(p)) inc = inc + CNT_W'(1);
                if (alloc_en[l] && alloc_idx[l] == PW'(p)) set_one = 1'b1;
            end
            dec = dec_en && (dec_idx == PW'(p));
            recount = '0;
            for (int a = 0; a < NARCH; a++) begin
                if (ret_next[a] == PW'(p)) recount = recount + CNT_W'(1);
            end
        end

        // Counter state
        always_ff @(posedge clk) begin
            if (!rst_n)
                cnt_q <= (p < NARCH) ? CNT_W'(1) : '0;
            else if (flush)
                cnt_q <= recount;
            else
                cnt_q <= (set_one ? CNT_W'(1) : cnt_q) + inc - CNT_W'(dec);
        end

        assign free_mask[p] = (cnt_q == '0);
    end

endmodule

// File: rtl/vmove_rename.sv
// Module vmove_rename
// Four-wide rename stage with zero-latency elimination of 128-bit vector
// register moves. Holds the speculative and retired maps, drives the
// registered renamed group, and ties together the free picker, the group
// resolver and the reference counters.
// Assumes one commit per cycle and that the upstream stage holds its group
// while stall is high.
module vmove_rename
    import rn_pkg::*;
#(
    parameter int LANES        = 4,
    parameter int ARCH_PER_CLS = 8,
    parameter int PHYS         = 48,
    parameter int CNT_W        = 6
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [LANES-1:0]                in_valid,
    input  logic [LANES-1:0]                in_move,
    input  logic [LANES-1:0]                in_wr,
    input  logic [2*LANES-1:0]              in_cls,
    input  logic [LANES*$clog2(ARCH_PER_CLS)-1:0] in_dst,
    input  logic [LANES*$clog2(ARCH_PER_CLS)-1:0] in_src_a,
    input  logic [LANES*$clog2(ARCH_PER_CLS)-1:0] in_src_b,
    input  logic                            flush,
    input  logic                            cm_valid,
    input  logic [1:0]                      cm_cls,
    input  logic [$clog2(ARCH_PER_CLS)-1:0] cm_arch,
    input  logic [$clog2(PHYS)-1:0]         cm_phys,
    output logic                            stall,
    output logic [LANES-1:0]                out_valid,
    output logic [LANES-1:0]                out_exec,
    output logic [LANES-1:0]                out_elim,
    output logic [LANES*$clog2(PHYS)-1:0]   out_psrc_a,
    output logic [LANES*$clog2(PHYS)-1:0]   out_psrc_b,
    output logic [LANES*$clog2(PHYS)-1:0]   out_pdst,
    output logic [LANES*$clog2(PHYS)-1:0]   out_pold
);

    localparam int NARCH = NUM_CLS * ARCH_PER_CLS;
    localparam int AIW   = $clog2(ARCH_PER_CLS);
    localparam int FW    = $clog2(NARCH);
    localparam int PW    = $clog2(PHYS);
    localparam int CW    = $clog2(LANES + 1);

    logic [LANES-1:0][1:0]     cls_v;
    logic [LANES-1:0][AIW-1:0] dst_v, sa_v, sb_v;
    assign cls_v = in_cls;
    assign dst_v = in_dst;
    assign sa_v  = in_src_a;
    assign sb_v  = in_src_b;

    logic [NARCH-1:0][PW-1:0] spec_map, ret_map, ret_next, map_next;
    logic [PHYS-1:0]          free_mask;
    logic [LANES-1:0][PW-1:0] pick, psa, psb, pdst, pold;
    logic [CW-1:0]            avail;
    logic [LANES-1:0]         writes, elim, alloc;
    logic                     need_more, do_ren;
    logic [FW-1:0]            cm_idx;
    logic [PW-1:0]            released;

    rn_free_pick #(.PHYS(PHYS), .LANES(LANES), .PW(PW), .CW(CW)) u_pick (
        .free_mask (free_mask),
        .pick      (pick),
        .avail     (avail)
    );

    rn_group_resolve #(.LANES(LANES), .NARCH(NARCH), .AIW(AIW), .PW(PW), .CW(CW)) u_resolve (
        .map_q     (spec_map),
        .valid     (in_valid),
        .move      (in_move),
        .wr        (in_wr),
        .cls       (cls_v),
        .dst       (dst_v),
        .sa        (sa_v),
        .sb        (sb_v),
        .pick      (pick),
        .avail     (avail),
        .writes    (writes),
        .elim      (elim),
        .alloc     (alloc),
        .psa       (psa),
        .psb       (psb),
        .pdst      (pdst),
        .pold      (pold),
        .need_more (need_more),
        .map_next  (map_next)
    );

    rn_refcount #(.PHYS(PHYS), .LANES(LANES), .NARCH(NARCH), .PW(PW), .CNT_W(CNT_W)) u_refs (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_en  (do_ren ? alloc : '0),
        .alloc_idx (pdst),
        .share_en  (do_ren ? elim : '0),
        .share_idx (psa),
        .dec_en    (cm_valid),
        .dec_idx   (released),
        .flush     (flush),
        .ret_next  (ret_next),
        .free_mask (free_mask)
    );

    // Group acceptance: flush drops the group, shortage stalls it
    assign do_ren = (|in_valid) && !flush && !need_more;
    assign stall  = (|in_valid) && !flush && need_more;

    // Retired map after this cycle's commit, and the register it displaces
    assign cm_idx   = {cm_cls, cm_arch};
    assign released = ret_map[cm_idx];
    always_comb begin
        ret_next = ret_map;
        if (cm_valid) ret_next[cm_idx] = cm_phys;
    end

    // Speculative and retired map state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < NARCH; a++) begin
                spec_map[a] <= PW'(a);
                ret_map[a]  <= PW'(a);
            end
        end else begin
            ret_map <= ret_next;
            if (flush)       spec_map <= ret_next;
            else if (do_ren) spec_map <= map_next;
        end
    end

    logic [LANES-1:0]         valid_q, exec_q, elim_q;
    logic [LANES-1:0][PW-1:0] psa_q, psb_q, pdst_q, pold_q;

    // Registered renamed group
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            exec_q  <= '0;
            elim_q  <= '0;
            psa_q   <= '0;
            psb_q   <= '0;
            pdst_q  <= '0;
            pold_q  <= '0;
        end else begin
            for (int j = 0; j < LANES; j++) begin
                valid_q[j] <= do_ren & in_valid[j];
                exec_q[j]  <= do_ren & in_valid[j] & ~elim[j];
                elim_q[j]  <= do_ren & elim[j];
                psa_q[j]   <= (do_ren && in_valid[j]) ? psa[j]  : '0;
                psb_q[j]   <= (do_ren && in_valid[j]) ? psb[j]  : '0;
                pdst_q[j]  <= (do_ren && in_valid[j]) ? pdst[j] : '0;
                pold_q[j]  <= (do_ren && in_valid[j]) ? pold[j] : '0;
            end
        end
    end

    assign out_valid  = valid_q;
    assign out_exec   = exec_q;
    assign out_elim   = elim_q;
    assign out_psrc_a = psa_q;
    assign out_psrc_b = psb_q;
    assign out_pdst   = pdst_q;
    assign out_pold   = pold_q;

endmodule

// File: rtl/vmove_rename_chk.sv
// Module vmove_rename_chk
// Temporal checks on the rename stage ports, bound into every instance.
// Assumes the same parameters as the bound instance.
module vmove_rename_chk #(
    parameter int LANES = 4,
    parameter int PW    = 6
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  flush,
    input logic                  stall,
    input logic [LANES-1:0]      in_valid,
    input logic [2*LANES-1:0]    in_cls,
    input logic [LANES-1:0]      out_valid,
    input logic [LANES-1:0]      out_exec,
    input logic [LANES-1:0]      out_elim,
    input logic [LANES*PW-1:0]   out_psrc_a,
    input logic [LANES*PW-1:0]   out_pdst
);

    assert_stall_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (out_valid == '0));

    assert_flush_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (out_valid == '0));

    assert_group_passes_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !flush) |=> (out_valid == $past(in_valid)));

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        assert_elim_copy_R2: assert property (@(posedge clk) disable iff (!rst_n)
            out_elim[j] |-> (!out_exec[j] && out_pdst[j*PW +: PW] == out_psrc_a[j*PW +: PW]));

        assert_elim_class_R3: assert property (@(posedge clk) disable iff (!rst_n)
            out_elim[j] |-> ($past(in_cls[2*j +: 2]) == 2'd1));
    end

endmodule

bind vmove_rename vmove_rename_chk #(.LANES(LANES), .PW(PW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .stall      (stall),
    .in_valid   (in_valid),
    .in_cls     (in_cls),
    .out_valid  (out_valid),
    .out_exec   (out_exec),
    .out_elim   (out_elim),
    .out_psrc_a (out_psrc_a),
    .out_pdst   (out_pdst)
);

// File: tb/vmove_rename_test.sv
// Bench for vmove_rename: a lane-vector table walked group by group,
// then directed sequences for stall, sharing, commit and flush.
module vmove_rename_test;

    localparam int CLK_PERIOD = 10;
    localparam int LANES = 4;
    localparam int AIW   = 3;
    localparam int PW    = 6;

    typedef struct packed {
        logic           v;
        logic           mv;
        logic           wr;
        logic [1:0]     cls;
        logic [AIW-1:0] dst;
        logic [AIW-1:0] sa;
        logic [AIW-1:0] sb;
        logic           ex;
        logic           el;
        logic [PW-1:0]  pdst;
        logic [PW-1:0]  psa;
        logic [PW-1:0]  pold;
    } lane_vec_t;

    localparam int NGRP = 3;
    localparam lane_vec_t VECS [NGRP*LANES] = '{
        '{1,0,1,0,1,2,3, 1,0,32, 2, 1},
        '{1,1,0,1,2,1,0, 0,1, 9, 9,10},
        '{1,0,1,1,3,2,0, 1,0,33, 9,11},
        '{1,1,0,0,4,1,0, 1,0,34,32, 4},
        '{1,1,0,2,0,1,0, 1,0,35,17,16},
        '{1,1,0,3,0,5,0, 1,0,36,29,24},
        '{1,1,0,1,4,3,0, 0,1,33,33,12},
        '{1,1,0,1,3,4,0, 0,1,33,33,33},
        '{1,0,1,0,1,1,0, 1,0,37,32,32},
        '{0,0,1,0,5,1,0, 0,0, 0, 0, 0},
        '{1,0,1,0,1,1,0, 1,0,38,37,37},
        '{1,0,0,0,0,1,0, 1,0, 0,38, 0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [LANES-1:0] in_valid, in_move, in_wr;
    logic [2*LANES-1:0] in_cls;
    logic [LANES*AIW-1:0] in_dst, in_src_a, in_src_b;
    logic flush, cm_valid;
    logic [1:0] cm_cls;
    logic [AIW-1:0] cm_arch;
    logic [PW-1:0] cm_phys;
    logic stall;
    logic [LANES-1:0] out_valid, out_exec, out_elim;
    logic [LANES*PW-1:0] out_psrc_a, out_psrc_b, out_pdst, out_pold;

    int checks = 0;
    int errors = 0;

    vmove_rename uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_move(in_move), .in_wr(in_wr),
        .in_cls(in_cls), .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b),
        .flush(flush), .cm_valid(cm_valid), .cm_cls(cm_cls), .cm_arch(cm_arch),
        .cm_phys(cm_phys), .stall(stall), .out_valid(out_valid), .out_exec(out_exec),
        .out_elim(out_elim), .out_psrc_a(out_psrc_a), .out_psrc_b(out_psrc_b),
        .out_pdst(out_pdst), .out_pold(out_pold)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_in();
        in_valid = '0; in_move = '0; in_wr = '0; in_cls = '0;
        in_dst = '0; in_src_a = '0; in_src_b = '0;
        flush = 1'b0; cm_valid = 1'b0; cm_cls = '0; cm_arch = '0; cm_phys = '0;
    endtask

    task automatic set_lane(input int l, input logic mv, input logic wr, input logic [1:0] cls,
                            input logic [AIW-1:0] d, input logic [AIW-1:0] a, input logic [AIW-1:0] b);
        in_valid[l] = 1'b1;
        in_move[l]  = mv;
        in_wr[l]    = wr;
        in_cls[2*l +: 2]     = cls;
        in_dst[l*AIW +: AIW]   = d;
        in_src_a[l*AIW +: AIW] = a;
        in_src_b[l*AIW +: AIW] = b;
    endtask

    task automatic commit(input logic [1:0] c, input logic [AIW-1:0] a, input logic [PW-1:0] p);
        cm_valid = 1'b1; cm_cls = c; cm_arch = a; cm_phys = p;
    endtask

    function automatic int pd(input int l);  return int'(out_pdst[l*PW +: PW]);   endfunction
    function automatic int ps(input int l);  return int'(out_psrc_a[l*PW +: PW]); endfunction
    function automatic int po(input int l);  return int'(out_pold[l*PW +: PW]);   endfunction

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        clear_in();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state of outputs
        chk("R11 out_valid after reset", int'(out_valid), 0);
        chk("R11 stall after reset", int'(stall), 0);

        // Table walk: identity map and ascending free pool from reset
        for (int g = 0; g < NGRP; g++) begin
            clear_in();
            for (int l = 0; l < LANES; l++) begin
                lane_vec_t e;
                e = VECS[g*LANES + l];
                if (e.v) set_lane(l, e.mv, e.wr, e.cls, e.dst, e.sa, e.sb);
                else begin
                    in_wr[l] = e.wr;
                    in_dst[l*AIW +: AIW] = e.dst;
                end
            end
            @(negedge clk);
            chk("R1 out_valid mirrors group", int'(out_valid), int'(in_valid));
            for (int l = 0; l < LANES; l++) begin
                lane_vec_t e;
                e = VECS[g*LANES + l];
                chk("R3 exec flag", int'(out_exec[l]), int'(e.ex));
                chk("R2 elim flag", int'(out_elim[l]), int'(e.el));
                chk("R6 pdst", pd(l), int'(e.pdst));
                chk("R4 source A", ps(l), int'(e.psa));
                chk("R5 old mapping", po(l), int'(e.pold));
            end
        end

        // Drain the pool down to one register
        clear_in();
        for (int l = 0; l < LANES; l++) set_lane(l, 1'b0, 1'b1, 2'd0, AIW'((l + 5) % 8), 3'd0, 3'd0);
        @(negedge clk);
        chk("R6 fourth alloc", pd(3), 42);
        clear_in();
        for (int l = 0; l < LANES; l++) set_lane(l, 1'b0, 1'b1, 2'd2, AIW'(l), 3'd0, 3'd0);
        @(negedge clk);
        chk("R6 x87 fourth alloc", pd(3), 46);

        // R8: two allocations with one free register
        clear_in();
        set_lane(0, 1'b0, 1'b1, 2'd0, 3'd5, 3'd5, 3'd0);
        set_lane(1, 1'b0, 1'b1, 2'd0, 3'd6, 3'd6, 3'd0);
        #1;
        chk("R8 stall raised", int'(stall), 1);
        @(negedge clk);
        chk("R8 stalled group not output", int'(out_valid), 0);

        clear_in();
        set_lane(0, 1'b0, 1'b1, 2'd0, 3'd2, 3'd5, 3'd0);
        set_lane(1, 1'b1, 1'b0, 2'd1, 3'd5, 3'd0, 3'd0);
        #1;
        chk("R8 one alloc fits", int'(stall), 0);
        @(negedge clk);
        chk("R8 map unchanged by stall", ps(0), 39);
        chk("R6 last free register", pd(0), 47);
        chk("R2 elim copies source", pd(1), 8);

        // R2: eliminated moves with an empty pool
        clear_in();
        set_lane(0, 1'b1, 1'b0, 2'd1, 3'd6, 3'd7, 3'd0);
        set_lane(1, 1'b1, 1'b0, 2'd1, 3'd7, 3'd6, 3'd0);
        #1;
        chk("R2 no stall on empty pool", int'(stall), 0);
        @(negedge clk);
        chk("R2 both eliminated", int'(out_elim), 3);
        chk("R4 forward of copied mapping", ps(1), 15);

        // R9: commit releases displaced register
        clear_in();
        commit(2'd0, 3'd1, 6'd32);
        @(negedge clk);
        clear_in();
        set_lane(0, 1'b0, 1'b1, 2'd1, 3'd1, 3'd1, 3'd0);
        @(negedge clk);
        chk("R9 released register reused", pd(0), 1);
        chk("R5 old vector mapping", po(0), 9);
        clear_in();
        commit(2'd1, 3'd2, 6'd9);
        @(negedge clk);
        clear_in();
        commit(2'd1, 3'd1, 6'd1);
        @(negedge clk);
        clear_in();
        set_lane(0, 1'b0, 1'b1, 2'd0, 3'd3, 3'd3, 3'd0);
        @(negedge clk);
        chk("R9 second release reused", pd(0), 10);

        // R7: shared register kept while still referenced
        clear_in();
        set_lane(0, 1'b0, 1'b1, 2'd0, 3'd3, 3'd3, 3'd0);
        #1;
        chk("R7 shared register not freed", int'(stall), 1);
        @(negedge clk);

        // R7: release and elimination on the same register in one cycle
        clear_in();
        commit(2'd1, 3'd2, 6'd33);
        set_lane(0, 1'b1, 1'b0, 2'd1, 3'd6, 3'd2, 3'd0);
        @(negedge clk);
        chk("R7 elim of released register", pd(0), 9);
        clear_in();
        set_lane(0, 1'b0, 1'b1, 2'd0, 3'd3, 3'd3, 3'd0);
        #1;
        chk("R7 same-cycle inc and dec cancel", int'(stall), 1);
        @(negedge clk);
        clear_in();
        commit(2'd1, 3'd4, 6'd33);
        @(negedge clk);
        clear_in();
        set_lane(0, 1'b0, 1'b1, 2'd0, 3'd4, 3'd4, 3'd0);
        @(negedge clk);
        chk("R7 only zero-count register allocated", pd(0), 12);
        chk("R4 speculative source", ps(0), 34);

        // R10: flush restores retired state
        clear_in();
        flush = 1'b1;
        set_lane(0, 1'b0, 1'b1, 2'd0, 3'd1, 3'd1, 3'd0);
        @(negedge clk);
        chk("R10 flushed group dropped", int'(out_valid), 0);
        clear_in();
        set_lane(0, 1'b0, 1'b1, 2'd0, 3'd1, 3'd1, 3'd0);
        set_lane(1, 1'b1, 1'b0, 2'd1, 3'd3, 3'd2, 3'd0);
        set_lane(2, 1'b0, 1'b1, 2'd0, 3'd2, 3'd1, 3'd0);
        @(negedge clk);
        chk("R10 retired source", ps(0), 32);
        chk("R10 recounted pool", pd(0), 9);
        chk("R10 retired vector copy", pd(1), 33);
        chk("R10 retired old mapping", po(1), 11);
        chk("R4 forward after flush", ps(2), 9);
        chk("R10 second recounted alloc", pd(2), 10);

        clear_in();
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule